// File: doc/BRIEF.md
# Bit-Serial Butterfly Base Index Generator

This block supplies the base index of each butterfly in one stage of a bit-serial FFT processor. The index lives in a single 10-bit circulating shift register. Each pass sends the register through a bit-serial half-adder, so the index grows by one while its old value streams out LSB first. In that same pass the block emits the Gray code of the index and its running parity. It also emits a 12-bit widened copy of the index, with two zero bits placed at a position chosen per pass. Once the index reaches 256, every butterfly of the stage has been issued. The index then returns to zero and the stage controller gets a one-cycle completion pulse.

A pass begins when `start` is seen while the block is idle. The index and the insertion position are captured at that moment. The pass then moves out twelve beats on a valid/ready stream. A beat transfers only in a cycle where `o_valid` and `o_ready` are both high. While the consumer holds `o_ready` low, the block holds every stream output at its value, and neither the index nor the parity advances. Each beat carries one bit of the widened index. On the ten beats that carry a register bit, `o_mbit_vld` is high, and on those beats the Gray and parity bits are valid as well. The pass closes with one extra bookkeeping cycle in which completion is decided.

Top module: `fft_base_index_gen`

## Requirements
- R1: After synchronous reset, `busy`, `o_valid` and `done` are low, and the first pass emits index 0.
- R2: `start` seen while idle raises `busy` and `o_valid` on the next cycle. Each pass moves exactly 12 beats, and `o_last` is high on the twelfth. `start` seen while busy has no effect on the pass under way.
- R3: Each pass emits the index held at its start and leaves that index plus one in the register. Index bits go out LSB first.
- R4: On the ten register-bit beats, `o_gray` carries bits 0..9 of m XOR (m >> 1), LSB first. Bit 9 therefore equals bit 9 of m.
- R5: On register-bit beat k, `o_par` equals the XOR of index bits 0..k. On the tenth such beat it equals the parity of the whole index.
- R6: With insertion position p, widened beat j carries index bit j for j < p, zero for j = p and j = p+1, and index bit j-2 for j > p+1. The value of p is captured at start, so later changes of `ins_pos` during a pass are ignored.
- R7: An `ins_pos` value above 10 behaves as 10, which places the two zeros at beats 10 and 11.
- R8: `o_mbit_vld` is high on exactly ten beats of a pass, and `o_mlast` is high on the tenth of them (index bit 9).
- R9: A beat transfers only when `o_valid` and `o_ready` are both high. While stalled, `o_valid`, `o_wide`, `o_gray`, `o_par` and `o_mbit_vld` stay unchanged.
- R10: The pass that emits index 255 increments it to 256. In the cycle after that pass's last beat, `done` is high for one cycle, and the next pass emits index 0. After every other pass, `done` stays low.
- R11: `busy` stays high from the cycle after start through the cycle after the last beat, then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass when idle |
| ins_pos | input | 4 | Beat position of the two inserted zeros (values above 10 treated as 10) |
| busy | output | 1 | Pass or its closing cycle in progress |
| done | output | 1 | One-cycle stage completion pulse |
| o_valid | output | 1 | Stream beat available |
| o_ready | input | 1 | Consumer accepts the beat |
| o_wide | output | 1 | Widened index bit for this beat |
| o_last | output | 1 | Twelfth beat of the pass |
| o_mbit_vld | output | 1 | Beat carries an index register bit |
| o_gray | output | 1 | Gray code bit (valid with o_mbit_vld) |
| o_par | output | 1 | Running parity bit (valid with o_mbit_vld) |
| o_mlast | output | 1 | Beat carries index bit 9 |

## Verification
The completion pulse is the hardest event to reach. It occurs only after 256 full passes with no reset in between. The stimulus therefore chains well over 256 randomized passes, so the wrap happens at least once. Along the way, random back-pressure lands stalls on inserted-zero beats and on register-bit beats alike. Directed passes cover insertion at beat 0, at beat 10, and with out-of-range positions. The insertion position is also changed randomly in the middle of passes.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fbi_state_e;
endpackage

// File: rtl/fbi_ser_inc.sv
// Circulating index register with a bit-serial half-adder.
module fbi_ser_inc #(
  parameter int IDX_W    = 10,
  parameter int DONE_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic shift,
  input  logic clr,
  output logic cur_bit,
  output logic nxt_bit,
  output logic full
);
  logic [IDX_W-1:0] m_q;
  logic             carry_q;
  logic             sum;

  assign sum     = m_q[0] ^ carry_q;
  assign cur_bit = m_q[0];
  assign nxt_bit = m_q[1];
  assign full    = m_q[DONE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q     <= '0;
      carry_q <= 1'b0;
    end else if (clr) begin
      m_q     <= '0;
      carry_q <= 1'b0;
    end else if (arm) begin
      carry_q <= 1'b1;
    end else if (shift) begin
      m_q     <= {sum, m_q[IDX_W-1:1]};
      carry_q <= m_q[0] & carry_q;
    end
  end

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (m_q == '0));
  // R3
  arm_carry_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> carry_q);
endmodule

// File: rtl/fbi_gray_par.sv
// Serial Gray encoder and running parity.
module fbi_gray_par (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic shift,
  input  logic cur_bit,
  input  logic nxt_bit,
  input  logic top_bit,
  output logic gray_bit,
  output logic par_bit
);
  logic acc_q;

  assign gray_bit = cur_bit ^ (top_bit ? 1'b0 : nxt_bit);
  assign par_bit  = acc_q ^ cur_bit;

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= 1'b0;
    else if (arm)   acc_q <= 1'b0;
    else if (shift) acc_q <= par_bit;
  end

  // R5
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift && !arm) |=> $stable(acc_q));
endmodule

// File: rtl/fbi_seq.sv
// Pass sequencer: beat counter, zero-insertion selector, state.
module fbi_seq
  import fbi_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [POS_W-1:0] ins_pos,
  input  logic             o_ready,
  output logic             arm,
  output logic             valid,
  output logic             shift,
  output logic             ins_beat,
  output logic             top_bit,
  output logic             last_beat,
  output logic             fin,
  output logic             busy
);
  localparam int OUT_W = IDX_W + 2;
  localparam int CW    = $clog2(IDX_W + 3);

  fbi_state_e       st;
  logic [CW-1:0]    bcnt;
  logic [CW-1:0]    pos_q;
  logic [CW-1:0]    pos_in;
  logic [CW-1:0]    idx;
  logic [CW-1:0]    sc;
  logic             fire;

  assign pos_in    = (CW'(ins_pos) > CW'(IDX_W)) ? CW'(IDX_W) : CW'(ins_pos);
  assign arm       = (st == ST_IDLE) && start;
  assign valid     = (st == ST_RUN);
  assign fin       = (st == ST_FIN);
  assign busy      = (st != ST_IDLE);
  assign fire      = valid && o_ready;
  assign ins_beat  = (bcnt == pos_q) || (bcnt == pos_q + CW'(1));
  assign idx       = (bcnt < pos_q) ? bcnt : bcnt - CW'(2);
  assign top_bit   = !ins_beat && (idx == CW'(IDX_W - 1));
  assign last_beat = valid && (bcnt == CW'(OUT_W - 1));
  assign shift     = fire && !ins_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      bcnt  <= '0;
      pos_q <= '0;
      sc    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_RUN;
          bcnt  <= '0;
          pos_q <= pos_in;
          sc    <= '0;
        end
        ST_RUN: if (fire) begin
          if (shift) sc <= sc + CW'(1);
          if (bcnt == CW'(OUT_W - 1)) st <= ST_FIN;
          else bcnt <= bcnt + CW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  shift_count_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (sc == CW'(IDX_W)));
  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (pos_q <= CW'(IDX_W)));
  // R11
  fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);
endmodule

// File: rtl/fft_base_index_gen.sv
module fft_base_index_gen #(
  parameter int IDX_W    = 10,
  parameter int DONE_BIT = 8,
  localparam int POS_W   = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [POS_W-1:0] ins_pos,
  output logic             busy,
  output logic             done,
  output logic             o_valid,
  input  logic             o_ready,
  output logic             o_wide,
  output logic             o_last,
  output logic             o_mbit_vld,
  output logic             o_gray,
  output logic             o_par,
  output logic             o_mlast
);
  logic arm, shift, ins_beat, top_bit, fin, full;
  logic cur_bit, nxt_bit, gray_bit, par_bit;

  fbi_seq #(.IDX_W(IDX_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .ins_pos(ins_pos), .o_ready(o_ready),
    .arm(arm), .valid(o_valid), .shift(shift), .ins_beat(ins_beat),
    .top_bit(top_bit), .last_beat(o_last), .fin(fin), .busy(busy)
  );

  fbi_ser_inc #(.IDX_W(IDX_W), .DONE_BIT(DONE_BIT)) u_inc (
    .clk(clk), .rst(rst), .arm(arm), .shift(shift), .clr(done),
    .cur_bit(cur_bit), .nxt_bit(nxt_bit), .full(full)
  );

  fbi_gray_par u_gp (
    .clk(clk), .rst(rst), .arm(arm), .shift(shift),
    .cur_bit(cur_bit), .nxt_bit(nxt_bit), .top_bit(top_bit),
    .gray_bit(gray_bit), .par_bit(par_bit)
  );

  assign done       = fin && full;
  assign o_mbit_vld = o_valid && !ins_beat;
  assign o_mlast    = o_mbit_vld && top_bit;
  assign o_wide     = ins_beat ? 1'b0 : cur_bit;
  assign o_gray     = gray_bit;
  assign o_par      = par_bit;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_wide) && $stable(o_gray)
                               && $stable(o_par) && $stable(o_mbit_vld)));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && o_valid));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R4
  gray_top_chk: assert property (@(posedge clk) disable iff (rst)
    o_mlast |-> (o_gray == o_wide));
  // R11
  last_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (o_last && o_ready) |=> (busy && !o_valid));
endmodule

// File: tb/sim_fft_base_index_gen.sv
`timescale 1ns/1ps
module sim_fft_base_index_gen;
  logic clk = 1'b0;
  logic rst, start, o_ready;
  logic [3:0] ins_pos;
  logic busy, done, o_valid, o_wide, o_last, o_mbit_vld, o_gray, o_par, o_mlast;

  int n_chk = 0;
  int n_fail = 0;
  int m_model = 0;

  always #2.5 clk = ~clk;

  fft_base_index_gen u0 (
    .clk(clk), .rst(rst), .start(start), .ins_pos(ins_pos), .busy(busy),
    .done(done), .o_valid(o_valid), .o_ready(o_ready), .o_wide(o_wide),
    .o_last(o_last), .o_mbit_vld(o_mbit_vld), .o_gray(o_gray), .o_par(o_par),
    .o_mlast(o_mlast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [11:0] exp_wide(input int m, input int p);
    logic [11:0] w = '0;
    for (int j = 0; j < 12; j++) begin
      if (j < p)           w[j] = m[j];
      else if (j < p + 2)  w[j] = 1'b0;
      else                 w[j] = m[j-2];
    end
    return w;
  endfunction

  function automatic logic [9:0] exp_gray(input int m);
    return 10'(m ^ (m >> 1));
  endfunction

  function automatic logic [9:0] exp_par(input int m);
    logic [9:0] v;
    logic a = 1'b0;
    for (int k = 0; k < 10; k++) begin
      a = a ^ m[k];
      v[k] = a;
    end
    return v;
  endfunction

  task automatic run_pass(input int p_in, input int stall_pct, input bit spam);
    int p = (p_in > 10) ? 10 : p_in;
    logic [11:0] wg = '0;
    logic [9:0] gg = '0, pg = '0;
    int beats = 0, mb = 0, guard = 0, last_at = -1;
    bit got_last = 0, stalled = 0;
    logic pw = 0, pgr = 0, ppa = 0, pmv = 0;
    bit exp_done;
    @(negedge clk);
    start = 1'b1; ins_pos = 4'(p_in); o_ready = 1'b0;
    @(negedge clk);
    start = spam;
    chk(busy && o_valid, "R2", "busy/valid after start", {busy, o_valid}, 3);
    while (!got_last && guard < 400) begin
      guard++;
      ins_pos = 4'($urandom % 16);
      if (stalled) begin
        chk(o_valid == 1'b1 && o_wide == pw && o_gray == pgr && o_par == ppa
            && o_mbit_vld == pmv, "R9", "held while stalled",
            {o_wide, o_gray, o_par, o_mbit_vld}, {pw, pgr, ppa, pmv});
      end
      o_ready = (($urandom % 100) >= stall_pct);
      stalled = o_valid && !o_ready;
      pw = o_wide; pgr = o_gray; ppa = o_par; pmv = o_mbit_vld;
      if (o_valid && o_ready) begin
        wg[beats] = o_wide;
        if (o_mbit_vld) begin
          gg[mb] = o_gray;
          pg[mb] = o_par;
          if (o_mlast) chk(mb == 9, "R8", "mlast position", mb, 9);
          mb++;
        end
        if (o_last) begin
          got_last = 1;
          last_at = beats;
          start = 1'b0;
        end
        beats++;
      end
      @(negedge clk);
    end
    chk(last_at == 11, "R2", "last beat index", last_at, 11);
    chk(mb == 10, "R8", "index bit beats", mb, 10);
    chk(wg == exp_wide(m_model, p), "R6", $sformatf("widened m=%0d p=%0d", m_model, p_in),
        wg, exp_wide(m_model, p));
    chk(gg == exp_gray(m_model), "R4", $sformatf("gray m=%0d", m_model), gg, exp_gray(m_model));
    chk(pg == exp_par(m_model), "R5", $sformatf("parity m=%0d", m_model), pg, exp_par(m_model));
    exp_done = (m_model == 255);
    chk(busy && !o_valid, "R11", "busy in closing cycle", {busy, o_valid}, 2);
    chk(done == exp_done, "R10", $sformatf("done after m=%0d", m_model), done, exp_done);
    o_ready = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after pass", {busy, done}, 0);
    m_model = exp_done ? 0 : m_model + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst = 1'b1; start = 1'b0; o_ready = 1'b0; ins_pos = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !o_valid && !done, "R1", "reset state", {busy, o_valid, done}, 0);
    // R1: first pass emits index 0, R3 chain follows
    run_pass(0, 0, 0);
    run_pass(10, 0, 0);
    run_pass(15, 30, 0);  // R7
    run_pass(11, 0, 1);   // R7, R2 start while busy
    run_pass(5, 60, 1);
    for (int i = 0; i < 300; i++)
      run_pass(int'($urandom % 16), int'($urandom % 50), bit'($urandom % 2));
    // R1: reset mid-stream restarts the index at 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_model = 0;
    @(negedge clk);
    chk(!busy && !o_valid, "R1", "reset again", {busy, o_valid}, 0);
    run_pass(3, 20, 0);
    run_pass(9, 0, 0);  // R3
    summary();
    $finish;
  end
endmodule